// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a logical address, given as a 16-bit selector plus an offset, into a linear address. It splits the selector into a segment number, a table bit and a requested privilege level. It checks the segment number against a per-table length register and looks up a descriptor in one of two descriptor stores. One store is global and shared by every process. The other is local and private to the running process.

Each descriptor holds a base, a limit, a valid flag, three access-right bits and a descriptor privilege level. If every check passes, the response carries base plus offset. If a check fails, the response carries a cause code instead.

Requests use a valid/ready handshake, and each accepted request produces one registered response. Privileged software loads descriptors and length registers through a separate configuration port. That port only takes effect when the privileged-mode input is high.

Top module: `seg_xlate_top`

## Requirements
- R1: Selector bits [15:3] give the segment number, bit [2] picks the table (0 global, 1 local), and bits [1:0] give the requested privilege level.
- R2: A segment number that is not below its table's length register, or not below that table's store depth, faults with cause 1.
- R3: A descriptor whose valid flag is 0 faults with cause 2.
- R4: An offset that is not below the descriptor limit faults with cause 3.
- R5: Access code 0 (read), 1 (write) and 2 (execute) needs rights bit 0, 1 and 2 respectively. Access code 3, a missing right, or a requested privilege numerically greater than the descriptor privilege faults with cause 4.
- R6: When several faults apply, the lowest-numbered cause among 1 to 4 is reported.
- R7: With no fault, the cause is 0, the fault flag is 0 and the linear address is base plus zero-extended offset, modulo 2^ADDR_W. On a fault the fault flag is 1 and the linear address is 0.
- R8: req_ready equals (not rsp_valid) or rsp_ready. An accepted request gives rsp_valid on the next cycle. A response is held unchanged while rsp_ready is low.
- R9: A configuration write takes effect only when both cfg_we and cfg_priv are high. cfg_len_sel=1 writes the length register of table cfg_tbl, and cfg_len_sel=0 writes descriptor cfg_idx of that table. A descriptor index at or beyond the store depth is ignored.
- R10: A request accepted in the same cycle as a write to its own descriptor or length register sees the old contents. The next request sees the new contents.
- R11: After reset there is no response pending, every descriptor is invalid and both length registers are 0, so any request faults with cause 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_sel | input | 16 | Selector |
| req_off | input | OFS_W | Offset within the segment |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_linear | output | ADDR_W | Linear address, 0 on fault |
| rsp_fault | output | 1 | Fault flag |
| rsp_cause | output | 3 | Fault cause code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Privileged-mode qualifier |
| cfg_len_sel | input | 1 | 1 writes the length register, 0 writes a descriptor |
| cfg_tbl | input | 1 | Target table: 0 global, 1 local |
| cfg_idx | input | 13 | Descriptor index |
| cfg_len | input | 14 | Length register value |
| cfg_base | input | ADDR_W | Descriptor base |
| cfg_limit | input | OFS_W | Descriptor limit |
| cfg_valid | input | 1 | Descriptor valid flag |
| cfg_rights | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| cfg_dpl | input | 2 | Descriptor privilege level |

## Verification
A descriptor or length write and a lookup of that same entry can land on the same clock edge. The bench provokes this with directed cases on one global entry and one length register. The random phase also drives a write and a request together in many steps. The expected result is always taken from the reference tables as they stood before the edge, and the tables are updated only afterwards. A lookup that picks up the new value early, or misses it on the following request, is reported as a mismatch.

// File: rtl/seg_pkg.sv
package seg_pkg;
   localparam int SEL_W = 16;
   localparam int SEG_W = 13;
   localparam int LEN_W = SEG_W + 1;
   localparam int RPL_W = 2;

   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_RANGE   = 3'd1,
      CAUSE_INVALID = 3'd2,
      CAUSE_LIMIT   = 3'd3,
      CAUSE_RIGHTS  = 3'd4
   } cause_e;

   typedef enum logic [1:0] {
      ACC_RD  = 2'd0,
      ACC_WR  = 2'd1,
      ACC_EX  = 2'd2,
      ACC_RSV = 2'd3
   } acc_e;
endpackage

// File: rtl/seg_desc_store.sv
module seg_desc_store
   import seg_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_priv,
   input  logic              wr_len_sel,
   input  logic [SEG_W-1:0]  wr_idx,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [OFS_W-1:0]  wr_limit,
   input  logic              wr_valid,
   input  logic [2:0]        wr_rights,
   input  logic [1:0]        wr_dpl,
   input  logic [SEG_W-1:0]  rd_idx,
   output logic              rd_in_range,
   output logic [ADDR_W-1:0] rd_base,
   output logic [OFS_W-1:0]  rd_limit,
   output logic              rd_valid,
   output logic [2:0]        rd_rights,
   output logic [1:0]        rd_dpl
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam logic [LEN_W-1:0] DEPTH_V = LEN_W'(DEPTH);

   generate
      if (DEPTH < 2 || DEPTH > 8191) begin : g_bad_depth
         $error("seg_desc_store: DEPTH must lie in 2..8191");
      end
   endgenerate

   logic [LEN_W-1:0]  len_q;
   logic [DEPTH-1:0]  valid_q;
   logic [ADDR_W-1:0] base_q   [DEPTH];
   logic [OFS_W-1:0]  limit_q  [DEPTH];
   logic [2:0]        rights_q [DEPTH];
   logic [1:0]        dpl_q    [DEPTH];

   logic             wr_ok, desc_hit, len_hit, rd_ok_depth;
   logic [IDX_W-1:0] wr_slot, rd_slot;

   assign wr_ok    = wr_en && wr_priv;
   assign desc_hit = wr_ok && !wr_len_sel && ({1'b0, wr_idx} < DEPTH_V);
   assign len_hit  = wr_ok && wr_len_sel;
   assign wr_slot  = wr_idx[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q   <= '0;
         valid_q <= '0;
         for (int e = 0; e < DEPTH; e++) begin
            base_q[e]   <= '0;
            limit_q[e]  <= '0;
            rights_q[e] <= '0;
            dpl_q[e]    <= '0;
         end
      end else begin
         if (len_hit) len_q <= wr_len;
         if (desc_hit) begin
            valid_q[wr_slot]  <= wr_valid;
            base_q[wr_slot]   <= wr_base;
            limit_q[wr_slot]  <= wr_limit;
            rights_q[wr_slot] <= wr_rights;
            dpl_q[wr_slot]    <= wr_dpl;
         end
      end
   end

   assign rd_ok_depth = ({1'b0, rd_idx} < DEPTH_V);
   assign rd_slot     = rd_idx[IDX_W-1:0];
   assign rd_in_range = rd_ok_depth && ({1'b0, rd_idx} < len_q);
   assign rd_base     = rd_ok_depth ? base_q[rd_slot]   : '0;
   assign rd_limit    = rd_ok_depth ? limit_q[rd_slot]  : '0;
   assign rd_valid    = rd_ok_depth ? valid_q[rd_slot]  : 1'b0;
   assign rd_rights   = rd_ok_depth ? rights_q[rd_slot] : '0;
   assign rd_dpl      = rd_ok_depth ? dpl_q[rd_slot]    : '0;

   // R9: without the privileged qualifier, nothing in the store changes
   a_r9_len_guard: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_priv |=> $stable(len_q));
   a_r9_desc_guard: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_priv |=> $stable(valid_q));
endmodule

// File: rtl/seg_fault_eval.sv
module seg_fault_eval
   import seg_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 20
) (
   input  logic              in_range,
   input  logic              d_valid,
   input  logic [ADDR_W-1:0] d_base,
   input  logic [OFS_W-1:0]  d_limit,
   input  logic [2:0]        d_rights,
   input  logic [1:0]        d_dpl,
   input  logic [1:0]        rpl,
   input  acc_e              acc,
   input  logic [OFS_W-1:0]  off,
   output cause_e            cause,
   output logic [ADDR_W-1:0] linear
);
   logic right_ok, priv_ok;

   always_comb begin
      unique case (acc)
         ACC_RD:  right_ok = d_rights[0];
         ACC_WR:  right_ok = d_rights[1];
         ACC_EX:  right_ok = d_rights[2];
         default: right_ok = 1'b0;
      endcase
   end

   assign priv_ok = (rpl <= d_dpl);

   // R6: first failing check in the fixed order wins
   always_comb begin
      if (!in_range)                  cause = CAUSE_RANGE;
      else if (!d_valid)              cause = CAUSE_INVALID;
      else if (off >= d_limit)        cause = CAUSE_LIMIT;
      else if (!right_ok || !priv_ok) cause = CAUSE_RIGHTS;
      else                            cause = CAUSE_NONE;
   end

   assign linear = (cause == CAUSE_NONE) ? (d_base + ADDR_W'(off)) : '0;
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
   import seg_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 20,
   parameter int GDEPTH = 16,
   parameter int LDEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [15:0]       req_sel,
   input  logic [OFS_W-1:0]  req_off,
   input  logic [1:0]        req_acc,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_linear,
   output logic              rsp_fault,
   output logic [2:0]        rsp_cause,
   input  logic              cfg_we,
   input  logic              cfg_priv,
   input  logic              cfg_len_sel,
   input  logic              cfg_tbl,
   input  logic [12:0]       cfg_idx,
   input  logic [13:0]       cfg_len,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [OFS_W-1:0]  cfg_limit,
   input  logic              cfg_valid,
   input  logic [2:0]        cfg_rights,
   input  logic [1:0]        cfg_dpl
);
   localparam int NTBL = 2;

   generate
      if (OFS_W < 1 || OFS_W > ADDR_W) begin : g_bad_ofs
         $error("seg_xlate_top: OFS_W must lie in 1..ADDR_W");
      end
   endgenerate

   // R1: selector field split
   logic [SEG_W-1:0] sel_seg;
   logic             sel_tbl;
   logic [RPL_W-1:0] sel_rpl;
   assign sel_seg = req_sel[15:3];
   assign sel_tbl = req_sel[2];
   assign sel_rpl = req_sel[1:0];

   logic              t_in_range [NTBL];
   logic [ADDR_W-1:0] t_base     [NTBL];
   logic [OFS_W-1:0]  t_limit    [NTBL];
   logic              t_valid    [NTBL];
   logic [2:0]        t_rights   [NTBL];
   logic [1:0]        t_dpl      [NTBL];

   generate
      for (genvar t = 0; t < NTBL; t++) begin : g_tbl
         localparam int TDEPTH = (t == 0) ? GDEPTH : LDEPTH;
         seg_desc_store #(
            .DEPTH (TDEPTH),
            .ADDR_W(ADDR_W),
            .OFS_W (OFS_W)
         ) u_store (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (cfg_we && (cfg_tbl == 1'(t))),
            .wr_priv    (cfg_priv),
            .wr_len_sel (cfg_len_sel),
            .wr_idx     (cfg_idx),
            .wr_len     (cfg_len),
            .wr_base    (cfg_base),
            .wr_limit   (cfg_limit),
            .wr_valid   (cfg_valid),
            .wr_rights  (cfg_rights),
            .wr_dpl     (cfg_dpl),
            .rd_idx     (sel_seg),
            .rd_in_range(t_in_range[t]),
            .rd_base    (t_base[t]),
            .rd_limit   (t_limit[t]),
            .rd_valid   (t_valid[t]),
            .rd_rights  (t_rights[t]),
            .rd_dpl     (t_dpl[t])
         );
      end
   endgenerate

   cause_e            ev_cause;
   logic [ADDR_W-1:0] ev_linear;

   seg_fault_eval #(
      .ADDR_W(ADDR_W),
      .OFS_W (OFS_W)
   ) u_eval (
      .in_range(t_in_range[sel_tbl]),
      .d_valid (t_valid[sel_tbl]),
      .d_base  (t_base[sel_tbl]),
      .d_limit (t_limit[sel_tbl]),
      .d_rights(t_rights[sel_tbl]),
      .d_dpl   (t_dpl[sel_tbl]),
      .rpl     (sel_rpl),
      .acc     (acc_e'(req_acc)),
      .off     (req_off),
      .cause   (ev_cause),
      .linear  (ev_linear)
   );

   // R8: one-deep response register
   logic              rsp_valid_q;
   logic [ADDR_W-1:0] rsp_linear_q;
   cause_e            rsp_cause_q;
   logic              accept;

   assign req_ready = !rsp_valid_q || rsp_ready;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q  <= 1'b0;
         rsp_linear_q <= '0;
         rsp_cause_q  <= CAUSE_NONE;
      end else if (accept) begin
         rsp_valid_q  <= 1'b1;
         rsp_linear_q <= ev_linear;
         rsp_cause_q  <= ev_cause;
      end else if (rsp_ready) begin
         rsp_valid_q  <= 1'b0;
      end
   end

   assign rsp_valid  = rsp_valid_q;
   assign rsp_linear = rsp_linear_q;
   assign rsp_cause  = rsp_cause_q;
   assign rsp_fault  = (rsp_cause_q != CAUSE_NONE);

   a_r8_accept_resp: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid);
   a_r8_hold_resp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_linear) && $stable(rsp_cause));
   a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_linear == '0);
endmodule

// File: tb/sim_seg_xlate_top.sv
module sim_seg_xlate_top;
   localparam int CLK_PER = 10;
   localparam int AW = 32;
   localparam int OW = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_ready, rsp_valid, rsp_ready = 1, rsp_fault;
   logic [15:0] req_sel = '0;
   logic [OW-1:0] req_off = '0;
   logic [1:0] req_acc = '0;
   logic [AW-1:0] rsp_linear;
   logic [2:0] rsp_cause;
   logic cfg_we = 0, cfg_priv = 0, cfg_len_sel = 0, cfg_tbl = 0, cfg_valid = 0;
   logic [12:0] cfg_idx = '0;
   logic [13:0] cfg_len = '0;
   logic [AW-1:0] cfg_base = '0;
   logic [OW-1:0] cfg_limit = '0;
   logic [2:0] cfg_rights = '0;
   logic [1:0] cfg_dpl = '0;

   always #(CLK_PER/2) clk = ~clk;

   seg_xlate_top u0 (.*);

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   // reference tables
   logic [AW-1:0] m_base [2][16];
   logic [OW-1:0] m_limit[2][16];
   logic          m_valid[2][16];
   logic [2:0]    m_rights[2][16];
   logic [1:0]    m_dpl[2][16];
   int            m_len[2];

   function automatic int tdepth(input logic t);
      return t ? 8 : 16;
   endfunction

   function automatic logic [2:0] ref_cause(input logic [15:0] sel, input logic [OW-1:0] off,
                                            input logic [1:0] acc);
      int seg = int'(sel[15:3]);
      logic t = sel[2];
      if (seg >= tdepth(t) || seg >= m_len[t]) return 3'd1;
      if (!m_valid[t][seg]) return 3'd2;
      if (off >= m_limit[t][seg]) return 3'd3;
      if (acc == 2'd3 || !m_rights[t][seg][acc] || sel[1:0] > m_dpl[t][seg]) return 3'd4;
      return 3'd0;
   endfunction

   function automatic logic [AW-1:0] ref_lin(input logic [15:0] sel, input logic [OW-1:0] off,
                                             input logic [2:0] c);
      if (c != 0) return '0;
      return m_base[sel[2]][sel[15:3]] + AW'(off);
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_write();
      if (cfg_we && cfg_priv) begin
         if (cfg_len_sel) m_len[cfg_tbl] = int'(cfg_len);
         else if (int'(cfg_idx) < tdepth(cfg_tbl)) begin
            m_base[cfg_tbl][cfg_idx[3:0]]   = cfg_base;
            m_limit[cfg_tbl][cfg_idx[3:0]]  = cfg_limit;
            m_valid[cfg_tbl][cfg_idx[3:0]]  = cfg_valid;
            m_rights[cfg_tbl][cfg_idx[3:0]] = cfg_rights;
            m_dpl[cfg_tbl][cfg_idx[3:0]]    = cfg_dpl;
         end
      end
   endtask

   // one step: optional config write and optional request on the same edge
   task automatic step(input bit wcfg, input bit wreq, input string tag);
      logic [2:0] ec;
      logic [AW-1:0] el;
      ec = ref_cause(req_sel, req_off, req_acc);
      el = ref_lin(req_sel, req_off, ec);
      cfg_we = wcfg;
      req_valid = wreq;
      @(posedge clk);
      model_write();
      @(negedge clk);
      cfg_we = 0;
      req_valid = 0;
      if (wreq) begin
         check({tag, " valid"}, 64'(rsp_valid), 64'd1);
         check({tag, " cause"}, 64'(rsp_cause), 64'(ec));
         check({tag, " fault"}, 64'(rsp_fault), 64'(ec != 0));
         check({tag, " linear"}, 64'(rsp_linear), 64'(el));
      end
      @(negedge clk);
   endtask

   task automatic set_desc(input logic priv, input logic t, input int idx, input logic [AW-1:0] b,
                           input logic [OW-1:0] lim, input logic v, input logic [2:0] r,
                           input logic [1:0] d);
      cfg_priv = priv; cfg_len_sel = 0; cfg_tbl = t; cfg_idx = 13'(idx);
      cfg_base = b; cfg_limit = lim; cfg_valid = v; cfg_rights = r; cfg_dpl = d;
   endtask

   task automatic set_len(input logic priv, input logic t, input int len);
      cfg_priv = priv; cfg_len_sel = 1; cfg_tbl = t; cfg_len = 14'(len);
   endtask

   task automatic set_req(input int seg, input logic t, input logic [1:0] rpl,
                          input logic [OW-1:0] off, input logic [1:0] acc);
      req_sel = {13'(seg), t, rpl}; req_off = off; req_acc = acc;
   endtask

   function automatic string tag_of(input logic [2:0] c);
      case (c)
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         default: return "R7";
      endcase
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [2:0] ec;
      void'($urandom(32'd4242));
      for (int t = 0; t < 2; t++) begin
         m_len[t] = 0;
         for (int e = 0; e < 16; e++) begin
            m_base[t][e] = '0; m_limit[t][e] = '0; m_valid[t][e] = 0;
            m_rights[t][e] = '0; m_dpl[t][e] = '0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      check("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      check("R11 req_ready after reset", 64'(req_ready), 64'd1);
      set_req(0, 0, 0, 0, 0);
      step(0, 1, "R11 empty tables");

      // R9 unprivileged writes ignored
      set_len(0, 0, 16);
      step(1, 0, "");
      set_req(1, 0, 0, 5, 0);
      step(0, 1, "R9 unprivileged length");
      set_len(1, 0, 16); step(1, 0, "");
      set_len(1, 1, 8);  step(1, 0, "");
      set_desc(1, 0, 1, 32'h1000_0000, 20'h100, 1, 3'b011, 2'd3); step(1, 0, "");
      set_desc(0, 0, 1, 32'h2222_0000, 20'h200, 0, 3'b000, 2'd0); step(1, 0, "");
      set_req(1, 0, 2, 20'h0ff, 1);
      step(0, 1, "R9 unprivileged descriptor");
      // R1 / R7 local table, field split
      set_desc(1, 1, 5, 32'hFFFF_FFF0, 20'h40, 1, 3'b100, 2'd2); step(1, 0, "");
      set_req(5, 1, 2, 20'h20, 2);
      step(0, 1, "R1 R7 local wrap");
      set_req(5, 0, 2, 20'h20, 2);
      step(0, 1, "R1 table bit global");
      // R4 boundary
      set_req(1, 0, 0, 20'h100, 0); step(0, 1, "R4 offset equals limit");
      // R5 privilege and reserved code
      set_req(5, 1, 3, 20'h0, 2); step(0, 1, "R5 rpl above dpl");
      set_req(1, 0, 0, 20'h0, 3); step(0, 1, "R5 reserved access");
      set_req(1, 0, 0, 20'h0, 2); step(0, 1, "R5 missing execute");
      // R2 beyond depth though length large
      set_len(1, 1, 100); step(1, 0, "");
      set_req(9, 1, 0, 0, 0); step(0, 1, "R2 beyond depth");
      // R9 index beyond depth ignored
      set_desc(1, 1, 8, 32'h5, 20'h5, 1, 3'b111, 2'd3); step(1, 0, "");
      set_req(0, 1, 0, 0, 0); step(0, 1, "R9 index beyond depth");
      // R6 priority
      set_desc(1, 0, 3, 32'h0, 20'h0, 0, 3'b000, 2'd0); step(1, 0, "");
      set_req(3, 0, 3, 20'hFFFF, 3); step(0, 1, "R6 invalid over limit");
      set_len(1, 0, 3); step(1, 0, "");
      set_req(3, 0, 3, 20'hFFFF, 3); step(0, 1, "R6 range first");
      set_len(1, 0, 16); step(1, 0, "");
      // R10 same-cycle write and lookup
      set_desc(1, 0, 2, 32'h0000_8000, 20'h10, 1, 3'b001, 2'd3);
      set_req(2, 0, 0, 20'h4, 0);
      step(1, 1, "R10 old descriptor");
      step(0, 1, "R10 new descriptor");
      set_len(1, 0, 2);
      step(1, 1, "R10 old length");
      step(0, 1, "R10 new length");
      set_len(1, 0, 16); step(1, 0, "");

      // R8 backpressure
      set_req(2, 0, 0, 20'h4, 0);
      ec = ref_cause(req_sel, req_off, req_acc);
      rsp_ready = 0; req_valid = 1;
      @(posedge clk); @(negedge clk);
      check("R8 response raised", 64'(rsp_valid), 64'd1);
      check("R8 ready low while held", 64'(req_ready), 64'd0);
      set_req(7, 1, 0, 20'h1, 1);
      @(posedge clk); @(negedge clk);
      check("R8 held cause", 64'(rsp_cause), 64'(ec));
      check("R8 held linear", 64'(rsp_linear), 64'h8004);
      req_valid = 0; rsp_ready = 1;
      @(posedge clk); @(negedge clk);
      check("R8 drained", 64'(rsp_valid), 64'd0);

      // constrained random
      for (int i = 0; i < 600; i++) begin
         bit wc, wr;
         wc = ($urandom % 4) == 0;
         wr = ($urandom % 5) != 0;
         if (($urandom % 8) == 0)
            set_len(($urandom % 8) != 0, 1'($urandom), int'($urandom % 20));
         else
            set_desc(($urandom % 8) != 0, 1'($urandom), int'($urandom % 20), $urandom,
                     OW'($urandom % 1024), ($urandom % 6) != 0, 3'($urandom), 2'($urandom));
         set_req(int'($urandom % 20), 1'($urandom), 2'($urandom), OW'($urandom % 1100),
                 2'($urandom));
         ec = ref_cause(req_sel, req_off, req_acc);
         step(wc, wr, tag_of(ec));
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule